// File: doc/BRIEF.md
# Periodic Entropy Reseed Requester

This block keeps a 128-bit reseed register topped up from an entropy source that runs on its own clock. A reseed is always made of two 64-bit fetches. Each fetch uses a level handshake in the entropy domain: the block raises a request and holds it until the source answers with an acknowledge and a data word. The first reseed starts only when a one-cycle advance command arrives. That command also moves the block out of its uninitialized state. From then on, a wait counter in the core domain paces the reseeds. It restarts each time a pair completes, and the next pair starts once the count reaches the programmed interval. A typical interval is 0x100 core cycles.

Requests cross from the core clock to the entropy clock as a toggle. Completions return the same way. Each completion becomes a one-cycle done event in the core domain. The word returned first fills the low half of the reseed register and the second word fills the high half. A one-cycle valid pulse marks the update. Each domain has its own asynchronous active-low reset, and a synchronized copy of each reset reaches the other domain. A reset on either side abandons any pair in flight.

Top module: `reseed_requester`

## Requirements
- R1: While and after reset, and before any stimulus, `ent_req_o` is 0, `seed_o` is all zeros and `seed_valid_o` is 0.
- R2: An `advance_i` pulse given while the block is uninitialized makes `ent_req_o` rise within 20 core cycles.
- R3: Of the two words of a reseed, the first one acknowledged lands in `seed_o[63:0]` and the second in `seed_o[127:64]`. `seed_valid_o` is high for exactly one core cycle when `seed_o` takes the new pair.
- R4: Once raised, `ent_req_o` stays high until a rising `ent_clk_i` edge samples `ent_ack_i` high. That edge captures `ent_data_i`, and `ent_req_o` is low after it.
- R5: After the first request of a pair falls, `ent_req_o` rises for the second word within 20 core cycles.
- R6: After each completed pair, the first request of the next pair rises no sooner than `interval_i` core cycles and no later than `interval_i`+20 core cycles after the `seed_valid_o` pulse. Reseeding continues indefinitely.
- R7: Without an `advance_i` pulse since reset, no request is ever raised and `seed_valid_o` never pulses, however long the wait.
- R8: Once the block is initialized, `advance_i` has no effect. This holds even in the cycle the wait counter becomes due: every reseed still raises exactly two requests.
- R9: A reset of the entropy domain in the middle of a pair behaves as follows:
  - `ent_req_o` drops and the half-built pair is discarded with no valid pulse.
  - After the reset releases, the wait count restarts from zero, so the next request comes between `interval_i` and `interval_i`+25 core cycles later.
  - The next reseed is built from two words acknowledged after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Core asynchronous reset, active low |
| ent_clk_i | input | 1 | Entropy-source clock |
| ent_rst_ni | input | 1 | Entropy-domain asynchronous reset, active low |
| advance_i | input | 1 | One-cycle command that initializes the block and starts the first reseed |
| interval_i | input | 16 | Core cycles to wait between the end of one pair and the next request |
| ent_req_o | output | 1 | Entropy request, entropy clock domain |
| ent_ack_i | input | 1 | Entropy acknowledge, entropy clock domain |
| ent_data_i | input | 64 | Entropy word, valid with `ent_ack_i` |
| seed_o | output | 128 | Assembled reseed register |
| seed_valid_o | output | 1 | One-cycle pulse when `seed_o` is updated |

## Verification
Two of the block's functions can coincide in one core cycle. One is the advance command. The other is the moment the wait counter reaches the interval and starts a reseed on its own. The bench provokes this by placing an advance pulse at seven consecutive offsets that straddle the expected due cycle. For each offset it judges the result at the ports: the reseed must contain exactly two request rises, and its start must still fall inside the interval window. A second collision is an entropy-domain reset arriving while the second word of a pair is outstanding. For that case the bench checks that no valid pulse appears, that the timer restarts, and that the following seed holds only words acknowledged after the reset.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;

  // Number of entropy words that make up one reseed
  localparam int unsigned RSQ_WORDS_PER_SEED = 2;

  // Core-side controller states
  typedef enum logic [1:0] {
    RSQ_IDLE  = 2'd0,  // not yet initialized, waits for advance
    RSQ_WAIT  = 2'd1,  // initialized, pacing counter running
    RSQ_FETCH = 2'd2   // one word request outstanding
  } rsq_state_e;

endpackage

// File: rtl/rsq_sync2.sv
`timescale 1ns/1ps
module rsq_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rsq_ent_port.sv
`timescale 1ns/1ps
module rsq_ent_port #(
  parameter int unsigned WORD_W      = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              ent_clk_i,
  input  logic              ent_rst_ni,
  input  logic              core_rst_ni,
  input  logic              req_tgl_i,
  input  logic              ent_ack_i,
  input  logic [WORD_W-1:0] ent_data_i,
  output logic              ent_req_o,
  output logic              ack_tgl_o,
  output logic [WORD_W-1:0] word_o
);

  // Core-reset status seen from the entropy clock
  logic core_ready;
  rsq_sync2 #(.STAGES(SYNC_STAGES)) u_core_ready_sync (
    .clk_i  (ent_clk_i),
    .rst_ni (core_rst_ni),
    .d_i    (1'b1),
    .q_o    (core_ready)
  );

  // Request toggle from the core domain
  logic req_sync;
  rsq_sync2 #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (ent_clk_i),
    .rst_ni (ent_rst_ni),
    .d_i    (req_tgl_i),
    .q_o    (req_sync)
  );

  logic              req_prev_q;
  logic              req_q;
  logic              ack_tgl_q;
  logic [WORD_W-1:0] word_q;

  // Named events for the assertions
  logic req_new;    // a fresh word request arrived from the core
  logic handshake;  // request and acknowledge meet at this edge
  assign req_new   = core_ready && (req_sync ^ req_prev_q);
  assign handshake = req_q && ent_ack_i;

  always_ff @(posedge ent_clk_i or negedge ent_rst_ni) begin
    if (!ent_rst_ni) begin
      req_prev_q <= 1'b0;
      req_q      <= 1'b0;
      ack_tgl_q  <= 1'b0;
      word_q     <= '0;
    end else begin
      req_prev_q <= req_sync;
      if (!core_ready) begin
        req_q     <= 1'b0;
        ack_tgl_q <= 1'b0;
      end else if (handshake) begin
        req_q     <= 1'b0;
        word_q    <= ent_data_i;
        ack_tgl_q <= ~ack_tgl_q;
      end else if (req_new) begin
        req_q <= 1'b1;
      end
    end
  end

  assign ent_req_o = req_q;
  assign ack_tgl_o = ack_tgl_q;
  assign word_o    = word_q;

  // R4: a raised request waits for its acknowledge
  p_req_hold_r4 : assert property (@(posedge ent_clk_i) disable iff (!ent_rst_ni)
    (ent_req_o && !ent_ack_i) |=> ent_req_o);

  // R4: request is withdrawn right after the acknowledge edge
  p_req_drop_r4 : assert property (@(posedge ent_clk_i) disable iff (!ent_rst_ni)
    (ent_req_o && ent_ack_i) |=> !ent_req_o);

endmodule

// File: rtl/rsq_core_fsm.sv
`timescale 1ns/1ps
module rsq_core_fsm
  import rsq_pkg::*;
#(
  parameter int unsigned WORD_W      = 64,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEED_W     = WORD_W * RSQ_WORDS_PER_SEED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ent_rst_ni,
  input  logic              advance_i,
  input  logic [CNT_W-1:0]  interval_i,
  input  logic              ack_tgl_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              req_tgl_o,
  output logic [SEED_W-1:0] seed_o,
  output logic              seed_valid_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Pacing arithmetic
  function automatic logic [CNT_W-1:0] wait_step(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  function automatic logic wait_due(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] limit);
    return c >= limit;
  endfunction

  function automatic logic [SEED_W-1:0] seed_join(input logic [WORD_W-1:0] lo,
                                                  input logic [WORD_W-1:0] hi);
    return {hi, lo};
  endfunction

  // Entropy-reset status seen from the core clock
  logic ent_ready;
  rsq_sync2 #(.STAGES(SYNC_STAGES)) u_ent_ready_sync (
    .clk_i  (clk_i),
    .rst_ni (ent_rst_ni),
    .d_i    (1'b1),
    .q_o    (ent_ready)
  );

  // Completion toggle from the entropy domain
  logic ack_sync;
  rsq_sync2 #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ack_tgl_i),
    .q_o    (ack_sync)
  );

  rsq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              hi_q;
  logic              req_tgl_q;
  logic              ack_seen_q;
  logic [WORD_W-1:0] lo_q;
  logic [SEED_W-1:0] seed_q;
  logic              valid_q;

  // Named events
  logic word_done;  // one word handshake finished
  logic first_go;   // launch of the first word of a pair
  logic second_go;  // launch of the second word of a pair
  logic pair_done;  // second word arrived
  logic launch;

  assign word_done = ent_ready && (state_q == RSQ_FETCH) && (ack_sync ^ ack_seen_q);
  assign first_go  = ent_ready &&
                     (((state_q == RSQ_IDLE) && advance_i) ||
                      ((state_q == RSQ_WAIT) && wait_due(cnt_q, interval_i)));
  assign second_go = word_done && !hi_q;
  assign pair_done = word_done && hi_q;
  assign launch    = first_go || second_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RSQ_IDLE;
      cnt_q      <= '0;
      hi_q       <= 1'b0;
      req_tgl_q  <= 1'b0;
      ack_seen_q <= 1'b0;
      lo_q       <= '0;
      seed_q     <= '0;
      valid_q    <= 1'b0;
    end else begin
      ack_seen_q <= ack_sync;
      valid_q    <= 1'b0;
      if (!ent_ready) begin
        // peer domain in reset: drop any pair in flight
        req_tgl_q <= 1'b0;
        hi_q      <= 1'b0;
        cnt_q     <= '0;
        if (state_q != RSQ_IDLE) state_q <= RSQ_WAIT;
      end else begin
        if (launch) req_tgl_q <= ~req_tgl_q;
        unique case (state_q)
          RSQ_IDLE: begin
            if (first_go) begin
              state_q <= RSQ_FETCH;
              hi_q    <= 1'b0;
            end
          end
          RSQ_WAIT: begin
            if (first_go) begin
              state_q <= RSQ_FETCH;
              hi_q    <= 1'b0;
            end else begin
              cnt_q <= wait_step(cnt_q);
            end
          end
          RSQ_FETCH: begin
            if (second_go) begin
              lo_q <= word_i;
              hi_q <= 1'b1;
            end else if (pair_done) begin
              seed_q  <= seed_join(lo_q, word_i);
              valid_q <= 1'b1;
              state_q <= RSQ_WAIT;
              cnt_q   <= '0;
              hi_q    <= 1'b0;
            end
          end
          default: state_q <= RSQ_IDLE;
        endcase
      end
    end
  end

  assign req_tgl_o    = req_tgl_q;
  assign seed_o       = seed_q;
  assign seed_valid_o = valid_q;

  // One-cycle-after-reset qualifier for the history-based properties
  logic chk_live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_live_q <= 1'b0;
    else         chk_live_q <= 1'b1;
  end

  // R3: valid is a single-cycle pulse
  p_valid_pulse_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_valid_o |=> !seed_valid_o);

  // R6: no launch from the wait state before the interval has elapsed
  p_launch_due_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_live_q && state_q == RSQ_WAIT && ent_ready && cnt_q < interval_i)
      |=> $stable(req_tgl_q));

  // R5: only one word outstanding at a time
  p_single_word_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_live_q && state_q == RSQ_FETCH && ent_ready && !word_done)
      |=> $stable(req_tgl_q));

  // R7: nothing is requested before the first advance
  p_idle_quiet_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_live_q && state_q == RSQ_IDLE && !advance_i) |=> $stable(req_tgl_q));

endmodule

// File: rtl/reseed_requester.sv
`timescale 1ns/1ps
module reseed_requester #(
  parameter int unsigned WORD_W      = 64,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEED_W     = WORD_W * rsq_pkg::RSQ_WORDS_PER_SEED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ent_clk_i,
  input  logic              ent_rst_ni,
  input  logic              advance_i,
  input  logic [CNT_W-1:0]  interval_i,
  output logic              ent_req_o,
  input  logic              ent_ack_i,
  input  logic [WORD_W-1:0] ent_data_i,
  output logic [SEED_W-1:0] seed_o,
  output logic              seed_valid_o
);

  logic              req_tgl;
  logic              ack_tgl;
  logic [WORD_W-1:0] ent_word;

  rsq_core_fsm #(
    .WORD_W      (WORD_W),
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ent_rst_ni   (ent_rst_ni),
    .advance_i    (advance_i),
    .interval_i   (interval_i),
    .ack_tgl_i    (ack_tgl),
    .word_i       (ent_word),
    .req_tgl_o    (req_tgl),
    .seed_o       (seed_o),
    .seed_valid_o (seed_valid_o)
  );

  rsq_ent_port #(
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ent (
    .ent_clk_i   (ent_clk_i),
    .ent_rst_ni  (ent_rst_ni),
    .core_rst_ni (rst_ni),
    .req_tgl_i   (req_tgl),
    .ent_ack_i   (ent_ack_i),
    .ent_data_i  (ent_data_i),
    .ent_req_o   (ent_req_o),
    .ack_tgl_o   (ack_tgl),
    .word_o      (ent_word)
  );

endmodule

// File: tb/reseed_requester_tb.sv
`timescale 1ns/1ps
module reseed_requester_tb;

  localparam int WW = 64;
  localparam int CW = 16;

  logic          clk = 1'b0, ent_clk = 1'b0;
  logic          rst_n = 1'b0, ent_rst_n = 1'b0;
  logic          advance = 1'b0;
  logic [CW-1:0] interval = '0;
  logic          ent_req, ent_ack;
  logic [WW-1:0] ent_data;
  logic [2*WW-1:0] seed;
  logic          seed_valid;

  initial forever #2.5 clk = ~clk;
  initial forever #3.5 ent_clk = ~ent_clk;

  reseed_requester u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ent_clk_i(ent_clk), .ent_rst_ni(ent_rst_n),
    .advance_i(advance), .interval_i(interval), .ent_req_o(ent_req),
    .ent_ack_i(ent_ack), .ent_data_i(ent_data), .seed_o(seed),
    .seed_valid_o(seed_valid)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string rq, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] wgen(input int i);
    logic [31:0] u;
    u = i;
    return {32'h5EED0000 + u * 32'd3, ~(u * 32'h01000193)};
  endfunction

  // Entropy source model, driven away from the entropy clock edge
  int ack_dly = 0, dcnt = 0, word_no = 0;
  bit stall = 0;
  initial begin
    ent_ack = 1'b0;
    ent_data = wgen(0);
    forever begin
      @(negedge ent_clk);
      if (!ent_rst_n) begin
        ent_ack = 1'b0;
        dcnt = 0;
      end else if (ent_ack && !ent_req) begin
        ent_ack = 1'b0;
        word_no++;
        ent_data = wgen(word_no);
        dcnt = 0;
      end else if (ent_req && !ent_ack && !stall) begin
        if (dcnt >= ack_dly) ent_ack = 1'b1;
        else dcnt++;
      end
    end
  end

  // Port monitor on the core clock
  int cyc = 0, adv_cyc = 0, rises = 0, nvalid = 0, since_valid = 0, since_fall = 0;
  bit mon_en = 0, req_prev = 0, valid_prev = 0;
  initial forever begin
    @(negedge clk);
    cyc++; since_valid++; since_fall++;
    if (rst_n) begin
      if (ent_req && !req_prev) begin
        if (mon_en) begin
          if (rises == 0)
            check(cyc - adv_cyc <= 20, "R2 first request latency", cyc - adv_cyc, 20);
          else if (rises % 2 == 1)
            check(since_fall < 20, "R5 second word gap", since_fall, 20);
          else
            check(since_valid >= int'(interval) && since_valid <= int'(interval) + 20,
                  "R6 periodic start window", since_valid, interval);
        end
        rises++;
      end
      if (!ent_req && req_prev && rises % 2 == 1) since_fall = 0;
      if (seed_valid) begin
        nvalid++;
        check(seed == {wgen(word_no - 1), wgen(word_no - 2)}, "R3 seed halves",
              seed, {wgen(word_no - 1), wgen(word_no - 2)});
        since_valid = 0;
        if (valid_prev) check(1'b0, "R3 valid width", 2, 1);
      end
    end
    req_prev = ent_req;
    valid_prev = seed_valid;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ent_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rises = 0; nvalid = 0; since_valid = 0; since_fall = 0;
    rst_n = 1'b1; ent_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_adv();
    @(negedge clk);
    advance = 1'b1;
    adv_cyc = cyc;
    @(negedge clk);
    advance = 1'b0;
  endtask

  task automatic wait_valid(input int target, input int maxc, output bit ok);
    int n = 0;
    while (nvalid < target && n < maxc) begin
      @(posedge clk);
      n++;
    end
    ok = (nvalid >= target);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    int nb, r0, cnt;
    int ivs[4] = '{0, 5, 33, 256};
    int dls[3] = '{0, 2, 5};

    // R1: reset state
    do_reset();
    @(posedge clk);
    check(ent_req == 1'b0, "R1 request idle", ent_req, 0);
    check(seed == '0, "R1 seed cleared", seed, 0);
    check(seed_valid == 1'b0, "R1 valid low", seed_valid, 0);

    // R7: nothing happens without advance
    interval = 5;
    repeat (300) @(posedge clk);
    check(rises == 0 && nvalid == 0, "R7 quiet before advance", rises + nvalid, 0);

    // Sweep of interval and acknowledge latency: R2, R3, R5, R6
    mon_en = 1;
    foreach (ivs[i]) begin
      foreach (dls[j]) begin
        do_reset();
        interval = ivs[i];
        ack_dly = dls[j];
        pulse_adv();
        for (int k = 1; k <= 3; k++) begin
          wait_valid(k, ivs[i] + 200, ok);
          check(ok, "R6 reseed keeps coming", nvalid, k);
        end
      end
    end

    // R4: request held through a long acknowledge stall
    do_reset();
    interval = 20; ack_dly = 0; stall = 1;
    pulse_adv();
    cnt = 0;
    while (!ent_req && cnt < 100) begin @(posedge clk); cnt++; end
    begin
      bit held = 1;
      for (int k = 0; k < 30; k++) begin
        @(negedge ent_clk);
        if (!ent_req) held = 0;
      end
      check(held, "R4 request held while unacknowledged", held, 1);
    end
    stall = 0;
    wait_valid(1, 200, ok);
    check(ok, "R4 pair completes after stall", nvalid, 1);

    // R8: advance collides with the due cycle at several offsets
    interval = 30;
    for (int off = 0; off < 7; off++) begin
      nb = nvalid;
      r0 = rises;
      repeat (27 + off) @(negedge clk);
      pulse_adv();
      wait_valid(nb + 1, 300, ok);
      @(posedge clk);
      check(ok && rises - r0 == 2, "R8 advance ignored once initialized", rises - r0, 2);
    end

    // R9: entropy reset while the second word is outstanding
    interval = 40;
    nb = nvalid;
    wait_valid(nb + 1, 300, ok);
    r0 = rises;
    while (rises < r0 + 1) @(posedge clk);
    while (ent_req) @(posedge clk);
    stall = 1;
    while (!ent_req) @(posedge clk);
    repeat (3) @(negedge clk);
    mon_en = 0;
    nb = nvalid;
    ent_rst_n = 1'b0;
    repeat (8) @(negedge clk);
    check(ent_req == 1'b0, "R9 request dropped in reset", ent_req, 0);
    stall = 0;
    ent_rst_n = 1'b1;
    cnt = 0;
    while (!ent_req && cnt < 500) begin @(posedge clk); cnt++; end
    check(nvalid == nb, "R9 partial pair discarded", nvalid, nb);
    check(cnt >= 40 && cnt <= 65, "R9 wait restarts after reset", cnt, 40);
    wait_valid(nb + 1, 300, ok);
    check(ok, "R9 reseeding resumes", nvalid, nb + 1);
    repeat (5) @(posedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule